// File: doc/BRIEF.md
# Microcoded Control Sequencer

This block is the control unit of a 16-bit load/store processor built around a microprogram. A 64-word control store, indexed by a 6-bit state number, holds one 35-bit microinstruction per state. Of each word, 26 bits steer the datapath and 9 bits decide which word is used next. The word for the next cycle is chosen while the current word drives the datapath, and both the state number and the selected word are captured at the same clock edge. The control outputs therefore come straight from a register.

The next-state logic has no general transition table. It takes the 6-bit jump target of the current word and ORs one status bit into a fixed bit of it. The 2-bit condition field picks which bit: memory ready, branch taken or addressing mode. When the word's dispatch flag is set, the target is instead the 4-bit opcode with two zero bits above it. The branch-taken bit is held in a flop inside the block. It is computed from three instruction bits and the N/Z/P condition codes, and the flop loads only when the current microinstruction asks for it. The control store is computed at elaboration by a function, not loaded from a file.

Top module: `ucode_sequencer`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it goes high, `state` is 18 and `ctrl` holds the control field of word 18.
- R2: `ctrl` always equals the control field of the word at `state` s: ctrl[25:0] = {s XOR 6'h2A, s, ~s, s[0], s, L}, where L is 1 only for s = 32. Word contents are as follows. States 18 and 19 jump to 33 with condition 00. State 33 jumps to 33 with condition 01. State 35 jumps to 32 with condition 00. State 32 has the dispatch flag set. State 0 jumps to 18 with condition 10. State 4 jumps to 20 with condition 11. Every other state jumps to 18 with condition 00.
- R3: Condition 00 leaves the jump target unchanged: 18 goes to 33, 35 goes to 32, and 22, 20, 21 and 15 go to 18.
- R4: Condition 01 ORs `mem_ready` into target bit 1. State 33 stays at 33 while `mem_ready` is 0 and moves to 35 on the edge where it is 1.
- R5: With the dispatch flag set, the next state is {2'b00, ir_top[6:3]}, where ir_top[6:3] is the opcode (instruction bits 15:12).
- R6: Condition 10 ORs the latched branch bit into target bit 2. From state 0 the next state is 22 if the bit is 1 and 18 if it is 0.
- R7: The branch bit is (ir_top[2] & cc_n) | (ir_top[1] & cc_z) | (ir_top[0] & cc_p), where ir_top[2:0] are instruction bits 11:9. It is loaded only at the edge that leaves a state whose ctrl[0] is 1 (state 32). Changes to the condition codes after that edge have no effect on the branch taken from state 0.
- R8: Condition 11 ORs ir_top[2] (instruction bit 11) into target bit 0. From state 4 the next state is 21 if that bit is 1 and 20 if it is 0.
- R9: The two unassigned opcodes 4'b1010 and 4'b1011 dispatch to states 10 and 11, and each of those returns to fetch state 18.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir_top | input | 7 | Instruction bits 15:9 (opcode in [6:3], bit 11 in [2]) |
| cc_n | input | 1 | Negative condition code |
| cc_z | input | 1 | Zero condition code |
| cc_p | input | 1 | Positive condition code |
| mem_ready | input | 1 | Memory access completes this cycle |
| state | output | 6 | Current microinstruction address |
| ctrl | output | 26 | Registered datapath control field |

## Verification
The assertions check the following on every cycle: that `ctrl` stays aligned with `state`, that the memory wait holds and exits correctly, that dispatch follows the opcode sampled in state 32, that the branch bit changes only when it is loaded, and that a branch state can only lead to 22 or 18. The bench scenarios are needed to show the exact state sequences through fetch, branch and addressing-mode paths and the illegal-opcode entries. They also show that the branch bit is computed correctly from each condition-code term, and that changing the condition codes after the branch bit is latched does not alter the branch.

// File: rtl/uc_pkg.sv
package uc_pkg;

  localparam int ADDR_W  = 6;
  localparam int CTRL_W  = 26;
  localparam int COND_W  = 2;
  localparam int WORD_W  = CTRL_W + ADDR_W + COND_W + 1;
  localparam int DEPTH   = 1 << ADDR_W;

  typedef enum logic [COND_W-1:0] {
    COND_NONE   = 2'b00,
    COND_READY  = 2'b01,
    COND_BRANCH = 2'b10,
    COND_MODE   = 2'b11
  } cond_e;

  typedef struct packed {
    logic [ADDR_W-1:0] j;
    cond_e             cond;
    logic              ird;
    logic [CTRL_W-1:0] ctl;
  } uword_t;

  // Microprogram: fetch loop, decode dispatch, branch and addressing-mode states.
  function automatic uword_t uc_word(input logic [ADDR_W-1:0] a);
    uword_t w;
    w.j    = 6'd18;
    w.cond = COND_NONE;
    w.ird  = 1'b0;
    w.ctl  = {a ^ 6'h2A, a, ~a, a[0], a, 1'b0};
    case (a)
      6'd18, 6'd19: w.j = 6'd33;
      6'd33: begin w.j = 6'd33; w.cond = COND_READY; end
      6'd35: w.j = 6'd32;
      6'd32: begin w.ird = 1'b1; w.ctl[0] = 1'b1; end
      6'd0:  begin w.j = 6'd18; w.cond = COND_BRANCH; end
      6'd4:  begin w.j = 6'd20; w.cond = COND_MODE; end
      default: ;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/uc_store.sv
module uc_store
  import uc_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output uword_t            word
);
  uword_t rom [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    assign rom[i] = uc_word(ADDR_W'(i));
  end

  assign word = rom[addr];
endmodule

// File: rtl/uc_ben.sv
module uc_ben (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [2:0] ir_nzp,
  input  logic       cc_n,
  input  logic       cc_z,
  input  logic       cc_p,
  output logic       ben
);
  logic ben_d;

  always_comb begin
    ben_d = (ir_nzp[2] & cc_n) | (ir_nzp[1] & cc_z) | (ir_nzp[0] & cc_p);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ben <= 1'b0;
    else if (load) ben <= ben_d;
  end
endmodule

// File: rtl/uc_nextaddr.sv
module uc_nextaddr
  import uc_pkg::*;
(
  input  logic [ADDR_W-1:0] j,
  input  cond_e             cond,
  input  logic              ird,
  input  logic [3:0]        opcode,
  input  logic              mode_bit,
  input  logic              ben,
  input  logic              ready,
  output logic [ADDR_W-1:0] next
);
  always_comb begin
    if (ird) begin
      next = {{(ADDR_W-4){1'b0}}, opcode};
    end else begin
      next = j;
      case (cond)
        COND_READY:  next[1] = j[1] | ready;
        COND_BRANCH: next[2] = j[2] | ben;
        COND_MODE:   next[0] = j[0] | mode_bit;
        default:     ;
      endcase
    end
  end
endmodule

// File: rtl/ucode_sequencer.sv
module ucode_sequencer
  import uc_pkg::*;
#(
  parameter logic [5:0] RESET_ADDR = 6'd18,
  parameter int         BEN_LD_BIT = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [6:0]   ir_top,
  input  logic         cc_n,
  input  logic         cc_z,
  input  logic         cc_p,
  input  logic         mem_ready,
  output logic [5:0]   state,
  output logic [25:0]  ctrl
);
  logic [ADDR_W-1:0] state_q, next_addr;
  uword_t            uinst_q, uinst_d;
  logic              ben_q;

  uc_ben u_ben (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (uinst_q.ctl[BEN_LD_BIT]),
    .ir_nzp (ir_top[2:0]),
    .cc_n   (cc_n),
    .cc_z   (cc_z),
    .cc_p   (cc_p),
    .ben    (ben_q)
  );

  uc_nextaddr u_next (
    .j        (uinst_q.j),
    .cond     (uinst_q.cond),
    .ird      (uinst_q.ird),
    .opcode   (ir_top[6:3]),
    .mode_bit (ir_top[2]),
    .ben      (ben_q),
    .ready    (mem_ready),
    .next     (next_addr)
  );

  uc_store u_store (
    .addr (next_addr),
    .word (uinst_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RESET_ADDR;
      uinst_q <= uc_word(RESET_ADDR);
    end else begin
      state_q <= next_addr;
      uinst_q <= uinst_d;
    end
  end

  assign state = state_q;
  assign ctrl  = uinst_q.ctl;
endmodule

// File: rtl/uc_checker.sv
module uc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [6:0] ir_top,
  input logic       mem_ready,
  input logic [5:0] state,
  input logic [5:0] ctrl_id,
  input logic       ben
);
  p_ctrl_tracks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |-> ctrl_id == state);

  p_wait_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 6'd33 && !mem_ready) |=> state == 6'd33);

  p_wait_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 6'd33 && mem_ready) |=> state == 6'd35);

  p_dispatch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 6'd32) |=> state == {2'b00, $past(ir_top[6:3])});

  p_br_target_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 6'd0) |=> (state == 6'd22 || state == 6'd18));

  p_ben_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state != 6'd32) |=> $stable(ben));
endmodule

bind ucode_sequencer uc_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ir_top    (ir_top),
  .mem_ready (mem_ready),
  .state     (state),
  .ctrl_id   (ctrl[6:1]),
  .ben       (ben_q)
);

// File: tb/tb_ucode_sequencer.sv
module tb_ucode_sequencer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [6:0]  ir_top;
  logic        cc_n, cc_z, cc_p, mem_ready;
  logic [5:0]  state;
  logic [25:0] ctrl;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [5:0] st;
    string      tag;
  } exp_t;
  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  ucode_sequencer dut (
    .clk(clk), .rst_n(rst_n), .ir_top(ir_top), .cc_n(cc_n), .cc_z(cc_z),
    .cc_p(cc_p), .mem_ready(mem_ready), .state(state), .ctrl(ctrl)
  );

  // Control field as given in R2.
  function automatic logic [25:0] exp_ctl(input logic [5:0] s);
    return {s ^ 6'h2A, s, ~s, s[0], s, (s == 6'd32)};
  endfunction

  task automatic check_now(input logic [5:0] st, input string tag);
    checks++;
    if (state !== st) begin
      errors++;
      $display("FAIL %s state: actual %0d expected %0d", tag, state, st);
    end
    checks++;
    if (ctrl !== exp_ctl(st)) begin
      errors++;
      $display("FAIL %s ctrl: actual %h expected %h", tag, ctrl, exp_ctl(st));
    end
  endtask

  // Driver: set inputs for the cycle, push the state expected after the edge.
  task automatic drive(input logic [6:0] ir, input logic [2:0] nzp,
                       input logic r, input logic [5:0] exp_st, input string tag);
    @(negedge clk);
    ir_top = ir;
    {cc_n, cc_z, cc_p} = nzp;
    mem_ready = r;
    sb.push_back('{exp_st, tag});
  endtask

  task automatic fetch(input logic [6:0] ir, input logic [2:0] nzp);
    drive(ir, nzp, 1'b0, 6'd33, "R3 fetch 18->33");
    drive(ir, nzp, 1'b1, 6'd35, "R4 ready exit");
    drive(ir, nzp, 1'b0, 6'd32, "R3 35->32");
  endtask

  // Monitor: compare a quarter period after each edge.
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (sb.size() > 0) begin
      exp_t it;
      it = sb.pop_front();
      check_now(it.st, it.tag);
    end
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; ir_top = '0; {cc_n, cc_z, cc_p} = 3'b000; mem_ready = 1'b0;
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/4);
    check_now(6'd18, "R1 in reset");
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check_now(6'd18, "R1 after release");

    // Memory wait in state 33 (R4)
    drive(7'b0000_000, 3'b000, 1'b0, 6'd33, "R3 fetch 18->33");
    drive(7'b0000_000, 3'b000, 1'b0, 6'd33, "R4 wait hold");
    drive(7'b0000_000, 3'b000, 1'b0, 6'd33, "R4 wait hold 2");
    drive(7'b0000_000, 3'b000, 1'b1, 6'd35, "R4 ready exit");
    drive(7'b0000_000, 3'b000, 1'b0, 6'd32, "R3 35->32");
    // BR, bits 11:9 = 101, Z only set: branch bit 0; then N set late is ignored (R7)
    drive(7'b0000_101, 3'b010, 1'b0, 6'd0,  "R5 dispatch BR");
    drive(7'b0000_101, 3'b100, 1'b0, 6'd18, "R7 late cc ignored / R6 not taken");

    // BR taken via Z term
    fetch(7'b0000_010, 3'b010);
    drive(7'b0000_010, 3'b010, 1'b0, 6'd0,  "R5 dispatch BR");
    drive(7'b0000_010, 3'b000, 1'b0, 6'd22, "R6 taken via z R7");
    drive(7'b0000_010, 3'b000, 1'b0, 6'd18, "R3 22->18");

    // BR taken via N term and via P term
    fetch(7'b0000_100, 3'b100);
    drive(7'b0000_100, 3'b100, 1'b0, 6'd0,  "R5 dispatch BR");
    drive(7'b0000_100, 3'b000, 1'b0, 6'd22, "R7 n term taken");
    drive(7'b0000_100, 3'b000, 1'b0, 6'd18, "R3 22->18");
    fetch(7'b0000_001, 3'b001);
    drive(7'b0000_001, 3'b001, 1'b0, 6'd0,  "R5 dispatch BR");
    drive(7'b0000_001, 3'b000, 1'b0, 6'd22, "R7 p term taken");
    drive(7'b0000_001, 3'b000, 1'b0, 6'd18, "R3 22->18");

    // Addressing mode (R8)
    fetch(7'b0100_100, 3'b000);
    drive(7'b0100_100, 3'b000, 1'b0, 6'd4,  "R5 dispatch op4");
    drive(7'b0100_100, 3'b000, 1'b0, 6'd21, "R8 mode bit 1");
    drive(7'b0100_100, 3'b000, 1'b0, 6'd18, "R3 21->18");
    fetch(7'b0100_000, 3'b111);
    drive(7'b0100_000, 3'b111, 1'b0, 6'd4,  "R5 dispatch op4");
    drive(7'b0100_000, 3'b111, 1'b0, 6'd20, "R8 mode bit 0");
    drive(7'b0100_000, 3'b111, 1'b0, 6'd18, "R3 20->18");

    // Illegal opcodes (R9)
    fetch(7'b1010_000, 3'b000);
    drive(7'b1010_000, 3'b000, 1'b0, 6'd10, "R9 opcode 1010");
    drive(7'b1010_000, 3'b000, 1'b0, 6'd18, "R9 10->18");
    fetch(7'b1011_111, 3'b000);
    drive(7'b1011_111, 3'b000, 1'b0, 6'd11, "R9 opcode 1011");
    drive(7'b1011_111, 3'b000, 1'b0, 6'd18, "R9 11->18");

    // Plain dispatch of opcode 1111
    fetch(7'b1111_000, 3'b000);
    drive(7'b1111_000, 3'b000, 1'b0, 6'd15, "R5 dispatch op15");
    drive(7'b1111_000, 3'b000, 1'b0, 6'd18, "R3 15->18");

    repeat (3) @(posedge clk);
    #(CLK_PERIOD/2);
    finish_run();
  end
endmodule